// File: doc/BRIEF.md
# Up-Counting Timer with Immediate or Deferred Compare Top

The block is a 16-bit up-counter that ends each period at a programmable top value, the compare value. When the count reaches the compare value, the counter returns to zero, a sticky match flag is raised, and an output pin toggles. All of this happens with no software involvement, so the pin carries a square wave whose half-period is set by the compare value.

Software chooses between two ways of loading a new compare value:

- **Clear-on-match mode.** A write replaces the active compare value at once. If the new value is below the current count, the match for this period is missed. The counter then runs to its maximum, wraps, and only matches on the next pass.
- **Buffered-top mode.** A write is parked in a holding register. It is copied into the active compare value on exactly the tick at which the counter sits at the old top. That is the same tick in which the counter clears and the overflow flag is raised. The current period is therefore never disturbed.

Ticks come from a free-running divider, selected by a 3-bit code. A two-state run controller (states `ST_STOP` and `ST_RUN`) gates the counter. It moves `ST_STOP -> ST_RUN` when a valid divide code is selected (transition "start"). It moves `ST_RUN -> ST_STOP` when the code is 000, 110 or 111 (transition "halt").

Top module: `cmp_timer`

## Requirements
- R1: After reset the count, the active compare value, the holding register, both flags, the interrupt output and the wave pin are all 0.
- R2: `clk_sel` picks the tick rate. 001 gives one tick per clock, 010 one per 8 clocks, 011 one per 64, 100 one per 256 and 101 one per 1024. Codes 000, 110 and 111 give no ticks, and the count holds.
- R3: In clear-on-match mode, a tick at which the count equals the active compare value returns the count to 0 and sets the match flag (`match_flag`) on that tick. The period is therefore compare+1 ticks. Any other tick adds one to the count.
- R4: In clear-on-match mode, a compare write (`cmp_wr`=1) is visible on `cmp_active` one clock later.
- R5: In clear-on-match mode, a compare value written below the current count is not matched. The count keeps rising to 0xFFFF, then wraps to 0, which sets the overflow flag. The next match occurs when the count reaches the new value.
- R6: In buffered-top mode, a compare write leaves `cmp_active` and the running period unchanged.
- R7: In buffered-top mode, the tick at which the count equals the active top clears the count, loads `cmp_active` from the holding register, and sets both the overflow flag and the match flag.
- R8: The flags are sticky. Writing 1 in `flag_clr` (bit 0 = match flag, bit 1 = overflow flag) clears a flag. A set event in the same cycle wins over the clear.
- R9: `irq` is high exactly when the match flag and `match_ie` are both high.
- R10: `wave` toggles on every compare match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_buf | input | 1 | 0 = clear-on-match, 1 = buffered top |
| clk_sel | input | 3 | Tick rate code |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | 16 | Compare write value |
| match_ie | input | 1 | Match interrupt enable |
| flag_clr | input | 2 | Write-1-to-clear: bit 0 match, bit 1 overflow |
| count | output | 16 | Current counter value |
| cmp_active | output | 16 | Compare value in use |
| match_flag | output | 1 | Sticky match flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Match interrupt request |
| wave | output | 1 | Toggle-on-match output pin |

## Verification
The bench writes a compare value below the running count in clear-on-match mode. It confirms that the count runs through 0xFFFF and wraps before the next match. A design that compared with `>=`, or that buffered in this mode, would clear early.

In buffered-top mode it writes a new top in mid-period. It checks that the old top still ends the period, and that the new value appears exactly in the clearing tick. A design that transferred at once, or one tick late, would show a short or misplaced period.

It sweeps several compare values, measuring periods and pin toggles, and every divide code, measuring tick counts over a fixed window.

It also drives a flag clear in the very cycle of a match. This catches a design that lets the clear win.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // log2 of the divide ratio for a tick code; -1 means no ticks
    function automatic int div_shift(input logic [2:0] code);
        case (code)
            3'd1:    return 0;
            3'd2:    return 3;
            3'd3:    return 6;
            3'd4:    return 8;
            3'd5:    return 10;
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/cmp_timer_prescale.sv
module cmp_timer_prescale
    import cmp_timer_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    output logic       tick
);

    logic [PRE_W-1:0] prediv_q;
    logic [PRE_W-1:0] mask;
    int               sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prediv_q <= '0;
        else        prediv_q <= prediv_q + 1'b1;
    end

    always_comb begin
        sh   = div_shift(clk_sel);
        mask = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < sh) mask[i] = 1'b1;
        end
        tick = (sh >= 0) && ((prediv_q & mask) == mask);
    end

endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_buf,
    input  logic             run_req,
    input  logic             tick,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cmp_active,
    output logic             adv,
    output logic             match_ev,
    output logic             ovf_ev
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, active_q, hold_q;
    logic             hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // next state and event decode
    always_comb begin
        unique case (state_q)
            ST_STOP: state_d = run_req ? ST_RUN  : ST_STOP;  // start
            ST_RUN:  state_d = run_req ? ST_RUN  : ST_STOP;  // halt
            default: state_d = ST_STOP;
        endcase
        adv      = (state_q == ST_RUN) && tick;
        hit      = (count_q == active_q);
        match_ev = adv && hit;
        ovf_ev   = adv && (mode_buf ? hit : (count_q == CNT_MAX));
    end

    // counter, holding register and active compare value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            active_q <= '0;
            hold_q   <= '0;
        end else begin
            if (cmp_wr) hold_q <= cmp_wdata;
            if (cmp_wr && !mode_buf) active_q <= cmp_wdata;
            if (adv) begin
                if (hit) begin
                    count_q <= '0;
                    if (mode_buf) active_q <= hold_q;
                end else begin
                    count_q <= count_q + 1'b1;
                end
            end
        end
    end

    assign count      = count_q;
    assign cmp_active = active_q;

endmodule

// File: rtl/cmp_timer_flags.sv
module cmp_timer_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match_ev,
    input  logic       ovf_ev,
    input  logic [1:0] flag_clr,
    input  logic       match_ie,
    output logic       match_flag,
    output logic       ovf_flag,
    output logic       irq,
    output logic       wave
);

    logic mf_q, of_q, wave_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mf_q   <= 1'b0;
            of_q   <= 1'b0;
            wave_q <= 1'b0;
        end else begin
            if (match_ev)         mf_q <= 1'b1;
            else if (flag_clr[0]) mf_q <= 1'b0;
            if (ovf_ev)           of_q <= 1'b1;
            else if (flag_clr[1]) of_q <= 1'b0;
            if (match_ev)         wave_q <= ~wave_q;
        end
    end

    assign match_flag = mf_q;
    assign ovf_flag   = of_q;
    assign wave       = wave_q;
    assign irq        = mf_q & match_ie;

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_buf,
    input  logic [2:0]       clk_sel,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             match_ie,
    input  logic [1:0]       flag_clr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cmp_active,
    output logic             match_flag,
    output logic             ovf_flag,
    output logic             irq,
    output logic             wave
);

    logic tick, run_req, adv, match_ev, ovf_ev;

    assign run_req = (div_shift(clk_sel) >= 0);

    cmp_timer_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_sel (clk_sel),
        .tick    (tick)
    );

    cmp_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_buf   (mode_buf),
        .run_req    (run_req),
        .tick       (tick),
        .cmp_wr     (cmp_wr),
        .cmp_wdata  (cmp_wdata),
        .count      (count),
        .cmp_active (cmp_active),
        .adv        (adv),
        .match_ev   (match_ev),
        .ovf_ev     (ovf_ev)
    );

    cmp_timer_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .match_ev   (match_ev),
        .ovf_ev     (ovf_ev),
        .flag_clr   (flag_clr),
        .match_ie   (match_ie),
        .match_flag (match_flag),
        .ovf_flag   (ovf_flag),
        .irq        (irq),
        .wave       (wave)
    );

endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_buf,
    input logic [2:0]       clk_sel,
    input logic             cmp_wr,
    input logic [CNT_W-1:0] cmp_wdata,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cmp_active,
    input logic             match_flag,
    input logic             ovf_flag,
    input logic             wave,
    input logic             adv,
    input logic             match_ev
);

    a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd0 || clk_sel > 3'd5) |=> $stable(count));

    a_r3_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_buf && adv && count == cmp_active) |=> (count == '0 && match_flag));

    a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_buf && adv && count != cmp_active) |=> (count == CNT_W'($past(count) + 1'b1)));

    a_r4_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && !mode_buf) |=> (cmp_active == $past(cmp_wdata)));

    a_r6_top_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_buf && !(adv && count == cmp_active)) |=> $stable(cmp_active));

    a_r7_top_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_buf && adv && count == cmp_active) |=> (count == '0 && ovf_flag && match_flag));

    a_r10_pin_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        match_ev |=> (wave != $past(wave)));

endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_buf   (mode_buf),
    .clk_sel    (clk_sel),
    .cmp_wr     (cmp_wr),
    .cmp_wdata  (cmp_wdata),
    .count      (count),
    .cmp_active (cmp_active),
    .match_flag (match_flag),
    .ovf_flag   (ovf_flag),
    .wave       (wave),
    .adv        (adv),
    .match_ev   (match_ev)
);

// File: tb/cmp_timer_test.sv
module cmp_timer_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_buf = 1'b0;
    logic [2:0]       clk_sel = 3'd0;
    logic             cmp_wr = 1'b0;
    logic [CNT_W-1:0] cmp_wdata = '0;
    logic             match_ie = 1'b0;
    logic [1:0]       flag_clr = 2'b00;
    logic [CNT_W-1:0] count, cmp_active;
    logic             match_flag, ovf_flag, irq, wave;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer uut (
        .clk(clk), .rst_n(rst_n), .mode_buf(mode_buf), .clk_sel(clk_sel),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .match_ie(match_ie),
        .flag_clr(flag_clr), .count(count), .cmp_active(cmp_active),
        .match_flag(match_flag), .ovf_flag(ovf_flag), .irq(irq), .wave(wave)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // runs at negedges; returns at the negedge where count == v
    task automatic wait_count(input logic [CNT_W-1:0] v, input string req);
        int guard = 0;
        while (count != v && guard < 70000) begin
            @(negedge clk);
            guard++;
        end
        if (count != v) check({req, " wait"}, count, v);
    endtask

    task automatic write_cmp(input logic [CNT_W-1:0] v);
        cmp_wr = 1'b1; cmp_wdata = v;
        @(negedge clk);
        cmp_wr = 1'b0;
    endtask

    task automatic clear_flags(input logic [1:0] m);
        flag_clr = m;
        @(negedge clk);
        flag_clr = 2'b00;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c0;
        logic w0;
        int divs [6] = '{0, 1, 8, 64, 256, 1024};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        check("R1 count", count, 0);
        check("R1 cmp_active", cmp_active, 0);
        check("R1 flags", {match_flag, ovf_flag, irq, wave}, 0);

        // R4 immediate write while stopped
        write_cmp(16'd1);
        check("R4 direct write", cmp_active, 1);

        // R3/R10 period sweep in clear-on-match mode, one tick per clock
        clk_sel = 3'd1;
        foreach (divs[i]) begin end
        for (int ci = 0; ci < 4; ci++) begin
            int c = (ci == 0) ? 1 : (ci == 1) ? 2 : (ci == 2) ? 5 : 37;
            write_cmp(CNT_W'(c));
            check("R4 direct write", cmp_active, c);
            wait_count(CNT_W'(c), "R3");
            clear_flags(2'b01);
            // that negedge count is 0 after the match
            check("R3 wrap to zero", count, 0);
            check("R3 match flag", match_flag, 1);
            for (int k = 1; k <= 2 * (c + 1); k++) begin
                w0 = wave;
                @(negedge clk);
                check("R3 count sequence", count, k % (c + 1));
                if (k % (c + 1) == 0) check("R10 toggle", wave, !w0);
                else                  check("R10 steady", wave, w0);
            end
        end

        // R2 divide codes
        write_cmp(16'hFFFF);
        for (int code = 0; code < 8; code++) begin
            int exp_d;
            clk_sel = 3'(code);
            repeat (3) @(negedge clk);
            c0 = count;
            repeat (4096) @(negedge clk);
            exp_d = (code >= 1 && code <= 5) ? 4096 / divs[code] : 0;
            check($sformatf("R2 code %0d ticks", code), (count - c0) & 16'hFFFF, exp_d);
        end

        // R5 missed match after a low write in clear-on-match mode
        clk_sel = 3'd1;
        wait_count(16'd6000, "R5");
        write_cmp(16'd100);
        clear_flags(2'b11);
        check("R5 no early clear", count > 16'd6000, 1);
        wait_count(16'hFFFF, "R5");
        check("R5 no match before wrap", match_flag, 0);
        @(negedge clk);
        check("R5 wrap count", count, 0);
        check("R5 overflow flag", ovf_flag, 1);
        wait_count(16'd100, "R5");
        check("R5 match flag pending", match_flag, 0);
        @(negedge clk);
        check("R5 late match", {count, match_flag}, {16'd0, 1'b1});

        // R6/R7 buffered top
        mode_buf = 1'b1;
        clear_flags(2'b11);
        wait_count(16'd50, "R6");
        write_cmp(16'd30);
        check("R6 active unchanged", cmp_active, 100);
        wait_count(16'd100, "R6");
        check("R6 period kept", {cmp_active, ovf_flag}, {16'd100, 1'b0});
        @(negedge clk);
        check("R7 clear and load", {count, cmp_active}, {16'd0, 16'd30});
        check("R7 flags", {ovf_flag, match_flag}, 2'b11);
        wait_count(16'd30, "R7");
        // R8 set wins over a same-cycle clear
        flag_clr = 2'b11;
        @(negedge clk);
        flag_clr = 2'b00;
        check("R7 new period", count, 0);
        check("R8 set beats clear", {match_flag, ovf_flag}, 2'b11);
        clear_flags(2'b01);
        check("R8 clear match only", {match_flag, ovf_flag}, 2'b01);
        clear_flags(2'b10);
        check("R8 clear overflow", {match_flag, ovf_flag}, 2'b00);

        // R9 interrupt gating
        match_ie = 1'b1;
        #1 check("R9 irq idle", irq, 0);
        wait_count(16'd30, "R9");
        @(negedge clk);
        #1 check("R9 irq raised", irq, 1);
        match_ie = 1'b0;
        #1 check("R9 irq masked", irq, 0);

        finish_run();
    end

endmodule